// File: doc/BRIEF.md
# Slave Serial Audio Port with Debug Freeze

This block carries 16-bit audio samples between a host and a serial link. The link is driven from outside: an external bit clock and an external long-format frame sync mark each frame. The sync stays high for the whole data word, and each frame moves one word out and one word in. The host writes outgoing samples into an 8-entry transmit queue and takes incoming samples from an 8-entry receive queue. It watches fill-level flags and two sticky error flags. A typical frame rate is 8 k frames per second.

The serial inputs are oversampled in the host clock domain through synchronizers, and bit-clock edges are detected there. A loopback control routes the outgoing serial stream into the receive shifter, so both paths can be tested without external wiring. A debug freeze input, which comes from another clock domain, stops all data movement and all flag changes. While freeze is active the host can still read the queue head, and host accesses leave the state untouched.

Top module: `aud_sport`

## Requirements
- R1: After reset both queues are empty: `tx_empty`=1, `rx_empty`=1, `tx_almost_empty`=1, `tx_full`=0, `rx_full`=0, `rx_almost_full`=0, both sticky flags 0, and `sd_out`=0.
- R2: A frame starts on the rising bit-clock edge where `fsync` is first seen high after being low at the previous rising edge. At that edge the head of the transmit queue is taken, and its 16 bits appear on `sd_out` MSB first, one bit per rising edge.
- R3: The receive shifter samples the serial input on the 16 falling bit-clock edges that follow a frame start, MSB first. The completed word is appended to the receive queue.
- R4: If the transmit queue is empty at a frame start, the frame sends all zeros and `tx_underrun` is set. It stays set until cleared.
- R5: A word that completes while the receive queue is full is dropped and `rx_overrun` is set. The queued words stay intact.
- R6: Each queue holds 8 words in first-in first-out order. A host write to a full transmit queue is discarded, and a read of an empty receive queue does nothing. `rx_rdata` always shows the oldest receive word.
- R7: `tx_almost_empty` is 1 when the transmit queue holds 2 or fewer words. `rx_almost_full` is 1 when the receive queue holds 6 or more words.
- R8: With `loopback`=1 the receive shifter takes the transmitted bit stream, so each sent word is received unchanged and `sd_in` is ignored.
- R9: While frozen, a word completed by the receive shifter is not stored.
- R10: While frozen, the transmit shifter loads no word at a frame start. The transmit queue is not popped, no underrun is recorded, and the frame sends zeros.
- R11: While frozen, host writes, host reads and `clr_sticky` change neither queue nor any flag. `rx_rdata` keeps showing the head word.
- R12: `freeze` passes through a two-stage synchronizer. A host write issued in the same clock as the rising freeze is still accepted.
- R13: A `clr_sticky` pulse while not frozen clears `tx_underrun` and `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, also used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External long frame sync, high across the data word |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| loopback | input | 1 | Route transmit stream into receive shifter |
| freeze | input | 1 | Asynchronous debug freeze request |
| tx_wr | input | 1 | Host write strobe for the transmit queue |
| tx_wdata | input | 16 | Host transmit word |
| rx_rd | input | 1 | Host read strobe, removes receive head |
| rx_rdata | output | 16 | Oldest receive word |
| clr_sticky | input | 1 | Clear both sticky error flags |
| tx_full | output | 1 | Transmit queue holds 8 words |
| tx_empty | output | 1 | Transmit queue holds no word |
| tx_almost_empty | output | 1 | Transmit queue holds 2 or fewer words |
| tx_underrun | output | 1 | Sticky: a frame started with the transmit queue empty |
| rx_full | output | 1 | Receive queue holds 8 words |
| rx_empty | output | 1 | Receive queue holds no word |
| rx_almost_full | output | 1 | Receive queue holds 6 or more words |
| rx_overrun | output | 1 | Sticky: a received word was dropped |

## Verification
The hardest case to reach is a frame that runs while the port is frozen. The host must have staged both queues and set a sticky flag beforehand. Then, during the freeze, it must issue writes, reads and clears that must all prove harmless. The bench prepares a receive word and a pending underrun, and it issues one write in the same clock that freeze rises. It then runs a complete serial frame while frozen. After release, further frames drain the transmit queue, and receive reads show exactly which words were kept and which were discarded.

// File: rtl/aud_pkg.sv
package aud_pkg;

  // fill level at or below a mark
  function automatic logic level_at_most(input int unsigned level, input int unsigned mark);
    return level <= mark;
  endfunction

  // fill level at or above a mark
  function automatic logic level_at_least(input int unsigned level, input int unsigned mark);
    return level >= mark;
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned wrap_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !hold;
  assign pop_ok  = pop && !empty && !hold;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(aud_pkg::wrap_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(aud_pkg::wrap_next(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_hold_keeps_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(count));
endmodule

// File: rtl/aud_serdes.sv
module aud_serdes #(
  parameter int W   = 16,
  localparam int BW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_s,
  input  logic         fs_s,
  input  logic         sdi_s,
  input  logic         loopback,
  input  logic         tx_take,
  input  logic         tx_zero,
  input  logic [W-1:0] tx_word,
  output logic         sd_out,
  output logic         frame_start,
  output logic         word_done,
  output logic [W-1:0] rx_word
);
  logic          bclk_q, fs_at_rise;
  logic          rise_ev, fall_ev;
  logic [W-1:0]  tx_sh, rx_sh;
  logic [BW-1:0] rx_cnt;
  logic          rx_act, rx_bit, last_bit;

  assign rise_ev     = bclk_s && !bclk_q;
  assign fall_ev     = !bclk_s && bclk_q;
  assign frame_start = rise_ev && fs_s && !fs_at_rise;
  assign sd_out      = tx_sh[W-1];
  assign rx_bit      = loopback ? tx_sh[W-1] : sdi_s;
  assign last_bit    = fall_ev && rx_act && (rx_cnt == BW'(W-1));
  assign rx_word     = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      fs_at_rise <= 1'b0;
    end else begin
      bclk_q <= bclk_s;
      if (rise_ev) fs_at_rise <= fs_s;
    end
  end

  // transmit: load at frame start, otherwise shift on each rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_sh <= '0;
    else if (tx_take) tx_sh <= tx_word;
    else if (tx_zero) tx_sh <= '0;
    else if (rise_ev) tx_sh <= {tx_sh[W-2:0], 1'b0};
  end

  // receive: 16 falling edges after the frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh     <= '0;
      rx_cnt    <= '0;
      rx_act    <= 1'b0;
      word_done <= 1'b0;
    end else begin
      word_done <= last_bit;
      if (frame_start) begin
        rx_act <= 1'b1;
        rx_cnt <= '0;
      end else if (fall_ev && rx_act) begin
        rx_sh  <= {rx_sh[W-2:0], rx_bit};
        rx_cnt <= rx_cnt + 1'b1;
        if (last_bit) rx_act <= 1'b0;
      end
    end
  end

  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> (sd_out == $past(tx_word[W-1])));

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_done) |-> !rx_act);
endmodule

// File: rtl/aud_sport.sv
module aud_sport #(
  parameter int WORD_W      = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int AE_MARK     = 2,
  parameter int AF_MARK     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              sd_in,
  output logic              sd_out,
  input  logic              loopback,
  input  logic              freeze,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_rdata,
  input  logic              clr_sticky,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_almost_empty,
  output logic              tx_underrun,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_almost_full,
  output logic              rx_overrun
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [2:0]        pins_s;
  logic              frz_s;
  logic              frame_start, word_done;
  logic              tx_take, tx_zero;
  logic [WORD_W-1:0] tx_head, rx_word;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

  aud_sync #(.W(3), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({bclk, fsync, sd_in}), .q(pins_s));

  aud_sync #(.W(1), .STAGES(SYNC_STAGES)) u_frz_sync (
    .clk(clk), .rst_n(rst_n), .d(freeze), .q(frz_s));

  assign tx_take = frame_start && !frz_s && !tx_empty;
  assign tx_zero = frame_start && !frz_s && tx_empty;

  aud_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .hold(frz_s),
    .push(tx_wr), .wdata(tx_wdata), .pop(tx_take),
    .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

  aud_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .hold(frz_s),
    .push(word_done), .wdata(rx_word), .pop(rx_rd),
    .rdata(rx_rdata), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

  aud_serdes #(.W(WORD_W)) u_serdes (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(pins_s[2]), .fs_s(pins_s[1]), .sdi_s(pins_s[0]),
    .loopback(loopback), .tx_take(tx_take), .tx_zero(tx_zero), .tx_word(tx_head),
    .sd_out(sd_out), .frame_start(frame_start), .word_done(word_done), .rx_word(rx_word));

  assign tx_almost_empty = aud_pkg::level_at_most(int'(tx_cnt), AE_MARK);
  assign rx_almost_full  = aud_pkg::level_at_least(int'(rx_cnt), AF_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
    end else if (!frz_s) begin
      if (tx_zero)                   tx_underrun <= 1'b1;
      else if (clr_sticky)           tx_underrun <= 1'b0;
      if (word_done && rx_full)      rx_overrun  <= 1'b1;
      else if (clr_sticky)           rx_overrun  <= 1'b0;
    end
  end

  assert_underrun_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underrun) |-> $past(frame_start));

  assert_overrun_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(word_done && rx_full));

  assert_frozen_rx_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && frz_s) |-> !rx_push_ok);

  assert_frozen_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frz_s |-> !tx_pop_ok);

  assert_sticky_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frz_s) |-> ($stable(tx_underrun) && $stable(rx_overrun)));
endmodule

// File: tb/tb_aud_sport.sv
module tb_aud_sport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, sd_in = 1'b0;
  logic        loopback = 1'b0, freeze = 1'b0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, clr_sticky = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic        sd_out;
  logic [15:0] rx_rdata;
  logic        tx_full, tx_empty, tx_almost_empty, tx_underrun;
  logic        rx_full, rx_empty, rx_almost_full, rx_overrun;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  aud_sport dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sd_in(sd_in),
    .sd_out(sd_out), .loopback(loopback), .freeze(freeze),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .clr_sticky(clr_sticky), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_almost_empty(tx_almost_empty), .tx_underrun(tx_underrun),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_almost_full(rx_almost_full),
    .rx_overrun(rx_overrun));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] w);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = w;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr_sticky = 1'b1;
    @(negedge clk); clr_sticky = 1'b0;
  endtask

  // one frame: 16 data bits with sync high, then 2 idle bits
  task automatic run_frame(input logic [15:0] din, output logic [15:0] dout);
    dout = '0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      bclk  = 1'b1;
      fsync = (i < 16);
      sd_in = (i < 16) ? din[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      bclk = 1'b0;
      repeat (8) @(negedge clk);
      if (i < 16) dout[15-i] = sd_out;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_almost_empty", tx_almost_empty, 1); chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_full", rx_full, 0); chk("R1 rx_almost_full", rx_almost_full, 0);
    chk("R1 sticky", {tx_underrun, rx_overrun}, 0); chk("R1 sd_out", sd_out, 0);
  endtask

  task automatic t_basic();
    logic [15:0] got;
    host_write(16'hA5C3);
    host_write(16'h1234);
    run_frame(16'h5A0F, got);
    chk("R2 first word msb first", got, 16'hA5C3);
    run_frame(16'hFFFF, got);
    chk("R2 second word", got, 16'h1234);
    @(negedge clk);
    chk("R3 received head", rx_rdata, 16'h5A0F);
    host_read();
    chk("R6 fifo order", rx_rdata, 16'hFFFF);
    host_read();
    chk("R6 rx empty after reads", rx_empty, 1);
    host_read();
    chk("R6 empty read ignored", rx_empty, 1);
    chk("R2 no underrun when words queued", tx_underrun, 0);
  endtask

  task automatic t_underrun();
    logic [15:0] got;
    run_frame(16'h0F0F, got);
    chk("R4 zeros on empty", got, 16'h0000);
    chk("R4 underrun set", tx_underrun, 1);
    pulse_clear();
    chk("R13 underrun cleared", tx_underrun, 0);
    host_read();
  endtask

  task automatic t_loopback_levels();
    logic [15:0] got;
    loopback = 1'b1;
    for (int i = 0; i < 8; i++) begin
      host_write(16'h1000 + 16'(i) * 16'h0111);
      @(negedge clk);
      if (i == 1) chk("R7 almost empty at 2", tx_almost_empty, 1);
      if (i == 2) chk("R7 not almost empty at 3", tx_almost_empty, 0);
    end
    chk("R6 tx full at 8", tx_full, 1);
    host_write(16'hDEAD);
    for (int i = 0; i < 8; i++) begin
      run_frame(16'hFFFF, got);
      chk("R8 loopback tx word", got, 16'h1000 + 16'(i) * 16'h0111);
      @(negedge clk);
      if (i == 4) chk("R7 not almost full at 5", rx_almost_full, 0);
      if (i == 5) chk("R7 almost full at 6", rx_almost_full, 1);
    end
    chk("R6 rx full at 8", rx_full, 1);
    chk("R5 no overrun yet", rx_overrun, 0);
    run_frame(16'hFFFF, got);
    chk("R6 write to full tx discarded", got, 16'h0000);
    chk("R5 overrun set", rx_overrun, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 looped word received", rx_rdata, 16'h1000 + 16'(i) * 16'h0111);
      host_read();
    end
    chk("R5 dropped word not stored", rx_empty, 1);
    pulse_clear();
    chk("R13 overrun cleared", rx_overrun, 0);
    loopback = 1'b0;
  endtask

  task automatic t_freeze();
    logic [15:0] got;
    run_frame(16'h3C3C, got);
    host_write(16'h0BEE);
    @(negedge clk);
    freeze = 1'b1; tx_wr = 1'b1; tx_wdata = 16'h4444;
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (4) @(negedge clk);
    host_write(16'h1111);
    host_read();
    pulse_clear();
    @(negedge clk);
    chk("R11 rx head kept", rx_rdata, 16'h3C3C);
    chk("R11 rx not emptied", rx_empty, 0);
    chk("R11 clear ignored", tx_underrun, 1);
    run_frame(16'h7777, got);
    chk("R10 frozen frame sends zeros", got, 16'h0000);
    chk("R10 tx not popped", tx_empty, 0);
    freeze = 1'b0;
    repeat (4) @(negedge clk);
    run_frame(16'h2222, got);
    chk("R10 held word sent after release", got, 16'h0BEE);
    run_frame(16'h5555, got);
    chk("R12 write at freeze edge accepted", got, 16'h4444);
    run_frame(16'h0000, got);
    chk("R11 frozen write discarded", got, 16'h0000);
    @(negedge clk);
    chk("R11 frozen read ignored", rx_rdata, 16'h3C3C);
    host_read();
    chk("R9 frozen word not stored", rx_rdata, 16'h2222);
    host_read();
    chk("R3 next word", rx_rdata, 16'h5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_underrun();
    t_loopback_levels();
    t_freeze();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule